// File: doc/BRIEF.md
# Element-Width Packed Register File

This block is a general register file of 64-bit registers that can also be read and written as narrower elements packed side by side inside those registers. An access names a base register, an element offset and an element width of 8, 16, 32 or 64 bits. From the offset and the width the block finds the physical register that holds the element and the lane it occupies. A read returns that lane, zero-extended to 64 bits. A write replaces that lane only and leaves the neighbouring lanes as they were.

There are two combinational read ports and one write port that commits on the rising clock edge. Each port has its own base, offset and width inputs. A destination-zeroing predicate on the write port stores zero into the selected lane instead of the supplied data. When an access would run past the last register, the port raises an out-of-range flag. An out-of-range read returns zero, and an out-of-range write is dropped.

Top module: `ew_regfile`

## Requirements
- R1: The width code is 2 bits: 00 = 64-bit, 01 = 32-bit, 10 = 16-bit, 11 = 8-bit. With code 00 the access uses the whole register at the base index, and the element offset is ignored.
- R2: For a narrower width w, with n = 64/w elements per register, the physical register is base + offset/n and the lane is offset mod n. Lane k occupies bits [k*w+w-1 : k*w].
- R3: A read returns the selected lane shifted down to bit 0. All bits above the element width are zero.
- R4: A write masks the incoming value to the element width and places it into the selected lane. Every other bit of that register keeps its previous value.
- R5: Write data is 128 bits wide. Only its low 64 bits take part in the write, and they are further masked to the element width.
- R6: When the zeroing predicate is high on a write, the selected lane becomes zero and the other lanes are unchanged.
- R7: Reads are combinational. A write takes effect at the rising clock edge. A read of the register being written in the same cycle returns the contents from before the write.
- R8: When base plus register step is 32 or more, the port's out-of-range flag is high, and a read on that port returns zero.
- R9: A write whose out-of-range flag is high changes no register.
- R10: A synchronous active-low reset clears every register to zero.
- R11: With the write enable low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ra_base | input | 5 | Read port A base register |
| ra_offs | input | 8 | Read port A element offset |
| ra_ew | input | 2 | Read port A width code |
| ra_data | output | 64 | Read port A element, zero-extended |
| ra_oor | output | 1 | Read port A out of range |
| rb_base | input | 5 | Read port B base register |
| rb_offs | input | 8 | Read port B element offset |
| rb_ew | input | 2 | Read port B width code |
| rb_data | output | 64 | Read port B element, zero-extended |
| rb_oor | output | 1 | Read port B out of range |
| wr_en | input | 1 | Write enable |
| wr_base | input | 5 | Write base register |
| wr_offs | input | 8 | Write element offset |
| wr_ew | input | 2 | Write width code |
| wr_zero | input | 1 | Destination-zeroing predicate |
| wr_data | input | 128 | Write data; only the low 64 bits are used |
| wr_oor | output | 1 | Write port out of range |

## Verification
The hardest case to reach from the ports is an out-of-range write whose truncated register index wraps onto register 0. The flaw it exposes only shows up if that register is read back afterwards. The stimulus issues a 32-bit write at base 30 with offset 4, which gives a register sum of exactly 32. It then reads register 0 and the top registers through the read ports to confirm that nothing moved. Partial-lane merges are reached by writing overlapping 8-, 16- and 32-bit lanes into one register and reading it back whole. A long random phase then drives all three ports at once, with a behavioural model that uses integer division and modulo, and compares every read every cycle.

// File: rtl/ew_regfile_pkg.sv
// Package: shared width encoding and lane helpers for the packed register file.
// Assumes registers are 64 bits wide; element widths are 64, 32, 16 or 8.
package ew_regfile_pkg;

    localparam int XLEN = 64;
    localparam int LANEW = 3;   // enough for 8 lanes of 8 bits

    typedef enum logic [1:0] {
        EW_64 = 2'b00,
        EW_32 = 2'b01,
        EW_16 = 2'b10,
        EW_8  = 2'b11
    } ew_e;

    // Mask covering one element of the given width at bit 0.
    function automatic logic [XLEN-1:0] ew_mask(input ew_e ew);
        case (ew)
            EW_64:   ew_mask = '1;
            EW_32:   ew_mask = 64'h0000_0000_FFFF_FFFF;
            EW_16:   ew_mask = 64'h0000_0000_0000_FFFF;
            default: ew_mask = 64'h0000_0000_0000_00FF;
        endcase
    endfunction

    // Bit position of a lane: lane index times element width.
    function automatic logic [5:0] lane_shift(input ew_e ew, input logic [LANEW-1:0] lane);
        case (ew)
            EW_64:   lane_shift = 6'd0;
            EW_32:   lane_shift = {lane[0], 5'b0};
            EW_16:   lane_shift = {lane[1:0], 4'b0};
            default: lane_shift = {lane, 3'b0};
        endcase
    endfunction

endpackage

// File: rtl/ew_addr_split.sv
// Module: splits base + element offset into a physical register and a lane.
// Assumes: at 64-bit width the offset is ignored; out of range when the
// register sum reaches NREG. The low bits of the sum are still driven then.
module ew_addr_split
    import ew_regfile_pkg::*;
#(
    parameter int NREG = 32,
    parameter int OFFW = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic [IDXW-1:0]  base,
    input  logic [OFFW-1:0]  offs,
    input  logic [1:0]       ew,
    output logic [IDXW-1:0]  phys,
    output logic [LANEW-1:0] lane,
    output logic             oor
);
    localparam int SUMW = ((IDXW > OFFW) ? IDXW : OFFW) + 1;

    logic [OFFW-1:0] step;
    logic [SUMW-1:0] sum;

    // Register step and lane index from the offset, per element width.
    always_comb begin
        case (ew_e'(ew))
            EW_64: begin
                step = '0;
                lane = '0;
            end
            EW_32: begin
                step = offs >> 1;
                lane = {2'b00, offs[0]};
            end
            EW_16: begin
                step = offs >> 2;
                lane = {1'b0, offs[1:0]};
            end
            default: begin
                step = offs >> 3;
                lane = offs[2:0];
            end
        endcase
    end

    // Physical register and range check on a widened sum.
    always_comb begin
        sum  = SUMW'(base) + SUMW'(step);
        oor  = (sum >= SUMW'(NREG));
        phys = sum[IDXW-1:0];
    end

endmodule

// File: rtl/ew_lane_extract.sv
// Module: pulls one element lane out of a 64-bit word and zero-extends it.
// Assumes: 'valid' low forces a zero result (used for out-of-range reads).
module ew_lane_extract
    import ew_regfile_pkg::*;
(
    input  logic [XLEN-1:0]  word,
    input  logic [1:0]       ew,
    input  logic [LANEW-1:0] lane,
    input  logic             valid,
    output logic [XLEN-1:0]  elem
);
    logic [5:0] sh;

    // Shift the lane down and mask to the element width.
    always_comb begin
        sh = lane_shift(ew_e'(ew), lane);
        if (valid) begin
            elem = (word >> sh) & ew_mask(ew_e'(ew));
        end else begin
            elem = '0;
        end
    end

endmodule

// File: rtl/ew_lane_merge.sv
// Module: merges a new element into one lane of an existing 64-bit word.
// Assumes: the caller supplies the current register contents as 'old'.
module ew_lane_merge
    import ew_regfile_pkg::*;
(
    input  logic [XLEN-1:0]  old,
    input  logic [XLEN-1:0]  data,
    input  logic [1:0]       ew,
    input  logic [LANEW-1:0] lane,
    input  logic             zero,
    output logic [XLEN-1:0]  merged
);
    logic [5:0]      sh;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] value;

    // Clear the target lane, then OR in the masked (or zeroed) value.
    always_comb begin
        sh     = lane_shift(ew_e'(ew), lane);
        mask   = ew_mask(ew_e'(ew));
        value  = zero ? '0 : (data & mask);
        merged = (old & ~(mask << sh)) | (value << sh);
    end

endmodule

// File: rtl/ew_reg_array.sv
// Module: NREG x XLEN storage, three combinational read ports, one write port.
// Assumes: the write address is in range whenever 'we' is high.
module ew_reg_array
    import ew_regfile_pkg::*;
#(
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [IDXW-1:0] raddr_a,
    input  logic [IDXW-1:0] raddr_b,
    input  logic [IDXW-1:0] raddr_w,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b,
    output logic [XLEN-1:0] rdata_w
);
    logic [NREG-1:0][XLEN-1:0] mem;

    // Storage update: synchronous clear, otherwise one word per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read ports see the contents held before any write in this cycle.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
    assign rdata_w = mem[raddr_w];

    // R11: without a write strobe the whole array holds.
    a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem));

endmodule

// File: rtl/ew_regfile.sv
// Module: top of the element-width packed register file.
// Two read ports and one read-modify-write port, each addressing sub-word lanes
// by base register, element offset and width code. Writes merge into the lane.
// Assumes: synchronous active-low reset; no write-to-read bypass.
module ew_regfile
    import ew_regfile_pkg::*;
#(
    parameter int NREG = 32,
    parameter int OFFW = 8,
    parameter int WDW  = 128,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] ra_base,
    input  logic [OFFW-1:0] ra_offs,
    input  logic [1:0]      ra_ew,
    output logic [XLEN-1:0] ra_data,
    output logic            ra_oor,
    input  logic [IDXW-1:0] rb_base,
    input  logic [OFFW-1:0] rb_offs,
    input  logic [1:0]      rb_ew,
    output logic [XLEN-1:0] rb_data,
    output logic            rb_oor,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_base,
    input  logic [OFFW-1:0] wr_offs,
    input  logic [1:0]      wr_ew,
    input  logic            wr_zero,
    input  logic [WDW-1:0]  wr_data,
    output logic            wr_oor
);
    localparam int NRD = 2;

    logic [IDXW-1:0]  rd_base [NRD];
    logic [OFFW-1:0]  rd_offs [NRD];
    logic [1:0]       rd_ew   [NRD];
    logic [IDXW-1:0]  rd_phys [NRD];
    logic [LANEW-1:0] rd_lane [NRD];
    logic             rd_oor  [NRD];
    logic [XLEN-1:0]  rd_word [NRD];
    logic [XLEN-1:0]  rd_elem [NRD];

    logic [IDXW-1:0]  w_phys;
    logic [LANEW-1:0] w_lane;
    logic             w_oor;
    logic [XLEN-1:0]  w_old;
    logic [XLEN-1:0]  w_merged;
    logic [XLEN-1:0]  w_data64;
    logic             w_we;
    logic             unused_wr_hi;

    // Gather the read ports into arrays for the per-port generate loop.
    always_comb begin
        rd_base[0] = ra_base;
        rd_offs[0] = ra_offs;
        rd_ew[0]   = ra_ew;
        rd_base[1] = rb_base;
        rd_offs[1] = rb_offs;
        rd_ew[1]   = rb_ew;
    end

    // One address splitter and lane extractor per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        ew_addr_split #(.NREG(NREG), .OFFW(OFFW)) u_split (
            .base (rd_base[p]),
            .offs (rd_offs[p]),
            .ew   (rd_ew[p]),
            .phys (rd_phys[p]),
            .lane (rd_lane[p]),
            .oor  (rd_oor[p])
        );

        ew_lane_extract u_extract (
            .word  (rd_word[p]),
            .ew    (rd_ew[p]),
            .lane  (rd_lane[p]),
            .valid (!rd_oor[p]),
            .elem  (rd_elem[p])
        );

        // R8: an out-of-range read port yields zero.
        a_r8_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rd_oor[p] |-> (rd_elem[p] == '0));

        // R3: nothing above the element width leaks out of a read.
        a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_elem[p] & ~ew_mask(ew_e'(rd_ew[p]))) == '0);
    end

    // Read port outputs.
    always_comb begin
        ra_data = rd_elem[0];
        ra_oor  = rd_oor[0];
        rb_data = rd_elem[1];
        rb_oor  = rd_oor[1];
    end

    // Write-side address split.
    ew_addr_split #(.NREG(NREG), .OFFW(OFFW)) u_wsplit (
        .base (wr_base),
        .offs (wr_offs),
        .ew   (wr_ew),
        .phys (w_phys),
        .lane (w_lane),
        .oor  (w_oor)
    );

    // Truncate write data to one register; the upper part is discarded.
    assign w_data64     = wr_data[XLEN-1:0];
    assign unused_wr_hi = ^wr_data[WDW-1:XLEN];

    // Lane merge against the current contents of the target register.
    ew_lane_merge u_merge (
        .old    (w_old),
        .data   (w_data64),
        .ew     (wr_ew),
        .lane   (w_lane),
        .zero   (wr_zero),
        .merged (w_merged)
    );

    // Commit only in-range writes.
    assign w_we   = wr_en && !w_oor;
    assign wr_oor = w_oor;

    ew_reg_array #(.NREG(NREG)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (w_we),
        .waddr   (w_phys),
        .wdata   (w_merged),
        .raddr_a (rd_phys[0]),
        .raddr_b (rd_phys[1]),
        .raddr_w (w_phys),
        .rdata_a (rd_word[0]),
        .rdata_b (rd_word[1]),
        .rdata_w (w_old)
    );

    // R4: the merged word carries the masked data in the target lane.
    a_r4_lane_gets_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_zero) |->
        (((w_merged >> lane_shift(ew_e'(wr_ew), w_lane)) & ew_mask(ew_e'(wr_ew)))
         == (w_data64 & ew_mask(ew_e'(wr_ew)))));

    // R4: bits outside the target lane equal the old register contents.
    a_r4_neighbours_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |->
        ((w_merged & ~(ew_mask(ew_e'(wr_ew)) << lane_shift(ew_e'(wr_ew), w_lane)))
         == (w_old & ~(ew_mask(ew_e'(wr_ew)) << lane_shift(ew_e'(wr_ew), w_lane)))));

    // R6: a zeroing write leaves the target lane clear.
    a_r6_zeroed_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_zero) |->
        (((w_merged >> lane_shift(ew_e'(wr_ew), w_lane)) & ew_mask(ew_e'(wr_ew))) == '0));

endmodule

// File: tb/test_ew_regfile.sv
`timescale 1ns/1ps
module test_ew_regfile;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [4:0]   ra_base, rb_base, wr_base;
    logic [7:0]   ra_offs, rb_offs, wr_offs;
    logic [1:0]   ra_ew, rb_ew, wr_ew;
    logic [63:0]  ra_data, rb_data;
    logic         ra_oor, rb_oor, wr_oor;
    logic         wr_en, wr_zero;
    logic [127:0] wr_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [63:0] model [32];

    always #10 clk = ~clk;   // 50 MHz

    ew_regfile i_ew_regfile (
        .clk(clk), .rst_n(rst_n),
        .ra_base(ra_base), .ra_offs(ra_offs), .ra_ew(ra_ew), .ra_data(ra_data), .ra_oor(ra_oor),
        .rb_base(rb_base), .rb_offs(rb_offs), .rb_ew(rb_ew), .rb_data(rb_data), .rb_oor(rb_oor),
        .wr_en(wr_en), .wr_base(wr_base), .wr_offs(wr_offs), .wr_ew(wr_ew),
        .wr_zero(wr_zero), .wr_data(wr_data), .wr_oor(wr_oor)
    );

    // Behavioural reference: width code to bits, integer division for placement.
    function automatic int bits_of(input logic [1:0] c);
        case (c)
            2'b00:   return 64;
            2'b01:   return 32;
            2'b10:   return 16;
            default: return 8;
        endcase
    endfunction

    function automatic logic [63:0] mask_of(input int w);
        return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic int reg_of(input int base, input int offs, input logic [1:0] c);
        int w = bits_of(c);
        if (w == 64) return base;
        return base + offs / (64 / w);
    endfunction

    function automatic int lane_of(input int offs, input logic [1:0] c);
        int w = bits_of(c);
        if (w == 64) return 0;
        return offs % (64 / w);
    endfunction

    function automatic logic [63:0] model_read(input int base, input int offs, input logic [1:0] c);
        int r = reg_of(base, offs, c);
        int w = bits_of(c);
        if (r >= 32) return 64'd0;
        return (model[r] >> (lane_of(offs, c) * w)) & mask_of(w);
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic setr(input int ab, input int ao, input logic [1:0] ae,
                        input int bb, input int bo, input logic [1:0] be);
        ra_base = 5'(ab); ra_offs = 8'(ao); ra_ew = ae;
        rb_base = 5'(bb); rb_offs = 8'(bo); rb_ew = be;
    endtask

    task automatic setw(input logic en, input int b, input int o, input logic [1:0] e,
                        input logic z, input logic [127:0] d);
        wr_en = en; wr_base = 5'(b); wr_offs = 8'(o); wr_ew = e; wr_zero = z; wr_data = d;
    endtask

    // One cycle: check reads mid-low-phase, then update the model at the edge.
    task automatic step(input string tag);
        int  ra_r = reg_of(ra_base, ra_offs, ra_ew);
        int  rb_r = reg_of(rb_base, rb_offs, rb_ew);
        int  wr_r = reg_of(wr_base, wr_offs, wr_ew);
        bit  a_o  = (ra_r >= 32);
        bit  b_o  = (rb_r >= 32);
        bit  w_o  = (wr_r >= 32);
        string ta = (tag != "") ? tag : (a_o ? "R8" : ((ra_ew == 2'b00) ? "R1" : "R3"));
        string tb = (tag != "") ? tag : (b_o ? "R8" : ((rb_ew == 2'b00) ? "R1" : "R3"));
        #5;
        chk(ta, "ra_data", ra_data, model_read(ra_base, ra_offs, ra_ew));
        chk(tb, "rb_data", rb_data, model_read(rb_base, rb_offs, rb_ew));
        chk("R8", "ra_oor", {63'd0, ra_oor}, {63'd0, a_o});
        chk("R8", "rb_oor", {63'd0, rb_oor}, {63'd0, b_o});
        chk("R9", "wr_oor", {63'd0, wr_oor}, {63'd0, w_o});
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) model[i] = 64'd0;
        end else if (wr_en && !w_o) begin
            int w = bits_of(wr_ew);
            int sh = lane_of(wr_offs, wr_ew) * w;
            logic [63:0] v = wr_zero ? 64'd0 : (wr_data[63:0] & mask_of(w));
            model[wr_r] = (model[wr_r] & ~(mask_of(w) << sh)) | (v << sh);
        end
        @(negedge clk);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 64'd0;
        rst_n = 1'b0;
        setr(0, 0, 2'b00, 31, 0, 2'b00);
        setw(1'b0, 0, 0, 2'b00, 1'b0, 128'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);

        // R10: reads during and after reset show cleared registers.
        step("R10");
        rst_n = 1'b1;
        for (int r = 0; r < 32; r++) begin
            setr(r, 0, 2'b00, 31 - r, 0, 2'b00);
            step("R10");
        end

        // R1/R5: 64-bit write at base 3 with nonzero offset; upper data discarded.
        setw(1'b1, 3, 5, 2'b00, 1'b0, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
        step("R1");
        setw(1'b0, 0, 0, 2'b00, 1'b0, 128'd0);
        setr(3, 9, 2'b00, 8, 0, 2'b00);
        step("R1");
        setr(3, 0, 2'b00, 3, 1, 2'b01);
        step("R5");

        // R2: 8-bit element at offset 11 from base 4 lands in register 5, lane 3.
        setw(1'b1, 4, 11, 2'b11, 1'b0, 128'hA5);
        step("R2");
        setw(1'b0, 0, 0, 2'b00, 1'b0, 128'd0);
        setr(5, 0, 2'b00, 4, 11, 2'b11);
        step("R2");

        // R4: 16-bit lane 2 and over-wide 8-bit lane 0 merge into register 5.
        setw(1'b1, 5, 2, 2'b10, 1'b0, 128'hFFFF_1234);
        step("R4");
        setw(1'b1, 5, 0, 2'b11, 1'b0, 128'h1FF);
        step("R4");
        setw(1'b0, 0, 0, 2'b00, 1'b0, 128'd0);
        setr(5, 0, 2'b00, 5, 2, 2'b10);
        step("R4");

        // R6: zeroing write on the upper 32-bit lane of an all-ones register.
        setw(1'b1, 7, 0, 2'b00, 1'b0, 128'hFFFF_FFFF_FFFF_FFFF);
        step("R6");
        setw(1'b1, 7, 1, 2'b01, 1'b1, 128'h1234_5678);
        step("R6");
        setw(1'b0, 0, 0, 2'b00, 1'b0, 128'd0);
        setr(7, 0, 2'b00, 7, 0, 2'b01);
        step("R6");

        // R7: same-cycle read sees the old value; the next cycle sees the new one.
        setr(9, 0, 2'b00, 9, 0, 2'b00);
        setw(1'b1, 9, 0, 2'b00, 1'b0, 128'hDEAD_BEEF);
        step("R7");
        setw(1'b0, 0, 0, 2'b00, 1'b0, 128'd0);
        step("R7");

        // R8: base 31 + step 1 overflows; base 20 + step 31 overflows.
        setr(31, 8, 2'b11, 31, 7, 2'b11);
        step("R8");
        setr(20, 255, 2'b11, 0, 255, 2'b11);
        step("R8");

        // R9: 32-bit write at base 30 offset 4 wraps to 32; register 0 must not change.
        setw(1'b1, 30, 4, 2'b01, 1'b0, 128'hFFFF_FFFF);
        setr(0, 0, 2'b00, 30, 0, 2'b00);
        step("R9");
        setw(1'b0, 0, 0, 2'b00, 1'b0, 128'd0);
        setr(0, 0, 2'b00, 31, 0, 2'b00);
        step("R9");

        // R11: write data present with enable low leaves register 3 unchanged.
        setw(1'b0, 3, 0, 2'b00, 1'b0, 128'hFFFF_FFFF_FFFF_FFFF);
        setr(3, 0, 2'b00, 5, 0, 2'b00);
        step("R11");
        step("R11");

        // R10: mid-run reset clears written registers.
        rst_n = 1'b0;
        setw(1'b0, 0, 0, 2'b00, 1'b0, 128'd0);
        step("R10");
        rst_n = 1'b1;
        setr(3, 0, 2'b00, 5, 0, 2'b00);
        step("R10");

        // Random traffic on all ports against the model.
        for (int k = 0; k < 600; k++) begin
            setr($urandom_range(0, 31), $urandom_range(0, 255), 2'($urandom_range(0, 3)),
                 $urandom_range(0, 31), $urandom_range(0, 40), 2'($urandom_range(0, 3)));
            setw(1'($urandom_range(0, 1)), $urandom_range(0, 31), $urandom_range(0, 60),
                 2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
                 {$urandom, $urandom, $urandom, $urandom});
            step("");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule